// File: doc/BRIEF.md
# Layered Normalized Min-Sum Decoder

This block is a belief-propagation decoder for a binary parity-check matrix that is fixed when the design is elaborated. A decode starts from a captured syndrome and one signed, fixed-point prior log-likelihood ratio (LLR) for each bit. It then walks the check rows in ascending order, one row per clock cycle. It repeats that sweep for a fixed, parameterized number of iterations. There is no early exit.

Every row update reads the current posterior of each bit in that row. It removes the row's previous check message to form the variable-to-check input, and it computes new check messages with a normalized min-sum rule. The syndrome bit steers the message sign. The posteriors are written back at once, so the next row already sees the refreshed values. The message store holds one entry per matrix edge and is zeroed when a decode begins.

When the sweep finishes, the block raises a one-cycle completion pulse. It then presents the posterior LLRs, and a hard-decision error estimate formed from their signs, to a downstream ordered-statistics stage.

Top module: `mn_layered_decoder`

## Requirements
- R1: After reset `busy` and `done` are 0, and every posterior LLR and hard-decision bit reads 0.
- R2: A `start` seen while idle loads the priors as posteriors, zeroes all check messages and captures `syndrome`. A `start` seen while `busy` is ignored and leaves the decode result unchanged.
- R3: Rows are updated in order 0 to NUM_CHK-1, one row per cycle, within every iteration. A row reads the posteriors written by the row before it.
- R4: For each bit in the current row, the variable-to-check value is the posterior minus that edge's stored message, saturated to the LLR range [-2^(LLR_W-1), 2^(LLR_W-1)-1].
- R5: The outgoing magnitude of an edge is the smallest magnitude among the row's other edges, scaled by 0.75 as m - (m>>2). Magnitudes are capped at 2^(LLR_W-1)-1, and a row with one edge uses that cap.
- R6: The outgoing message is negative exactly when the XOR of the row's syndrome bit with the sign bits of the row's other edges is 1. A sign bit is 1 for a negative variable-to-check value.
- R7: The new posterior of a row bit is its variable-to-check value plus its new message, saturated to the LLR range. Bits outside the row keep their posterior.
- R8: A decode takes exactly NUM_ITER*NUM_CHK update cycles. `done` is high for one cycle, in the cycle after the last update, and `busy` falls at the same time.
- R9: Hard-decision bit j is 1 exactly when posterior j is negative.
- R10: While idle and without `start`, the posterior and hard-decision outputs stay constant, whatever the prior inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode (taken only while idle) |
| syndrome | input | NUM_CHK | Syndrome, bit r for check row r |
| prior_llr | input | NUM_VAR*LLR_W | Signed prior LLRs, bit j at [j*LLR_W +: LLR_W] |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| post_llr | output | NUM_VAR*LLR_W | Signed posterior LLRs, same packing as the priors |
| hard_dec | output | NUM_VAR | Hard-decision error estimate |

## Verification
The bench targets priors pinned at both saturation limits. A design that wraps instead of clamping would flip the sign of a posterior there, and with it the hard decision. It also targets the two-edge row, where the edge holding the smallest magnitude must take the second smallest. Code that excluded the wrong edge would echo a bit's own reliability back to it. An all-ones syndrome checks that every message sign inverts. A `start` pulsed mid-decode with different priors must leave the result untouched, so a controller that restarted would show a different posterior set. The bench also counts the latency to the completion pulse exactly and watches the outputs while the priors change during idle.

// File: rtl/mn_pkg.sv
package mn_pkg;
  typedef enum logic [1:0] {
    MN_IDLE = 2'd0,
    MN_RUN  = 2'd1
  } mn_phase_e;
endpackage

// File: rtl/mn_ctrl.sv
module mn_ctrl #(
  parameter int NUM_CHK  = 4,
  parameter int NUM_ITER = 2,
  localparam int ROW_W   = (NUM_CHK > 1) ? $clog2(NUM_CHK) : 1,
  localparam int IT_W    = (NUM_ITER > 1) ? $clog2(NUM_ITER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             load,
  output logic [ROW_W-1:0] row_q
);
  import mn_pkg::*;

  mn_phase_e            phase_q;
  logic [IT_W-1:0]      iter_q;
  logic                 row_last;
  logic                 iter_last;

  assign busy      = (phase_q == MN_RUN);
  assign load      = start && !busy;
  assign row_last  = (row_q == ROW_W'(NUM_CHK - 1));
  assign iter_last = (iter_q == IT_W'(NUM_ITER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= MN_IDLE;
      row_q   <= '0;
      iter_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        phase_q <= MN_RUN;
        row_q   <= '0;
        iter_q  <= '0;
      end else if (busy) begin
        if (row_last) begin
          row_q <= '0;
          if (iter_last) begin
            phase_q <= MN_IDLE;
            done    <= 1'b1;
          end else begin
            iter_q <= iter_q + 1'b1;
          end
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(row_q) < NUM_CHK)); // R3
  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (row_q == (($past(row_q) == ROW_W'(NUM_CHK - 1)) ? '0 : $past(row_q) + 1'b1))); // R3
endmodule

// File: rtl/mn_row_update.sv
module mn_row_update #(
  parameter int NUM_VAR = 8,
  parameter int LLR_W   = 8
) (
  input  logic [NUM_VAR-1:0]       edge_mask,
  input  logic                     syn_bit,
  input  logic signed [LLR_W-1:0]  post_in  [NUM_VAR],
  input  logic signed [LLR_W-1:0]  msg_in   [NUM_VAR],
  output logic signed [LLR_W-1:0]  post_out [NUM_VAR],
  output logic signed [LLR_W-1:0]  msg_out  [NUM_VAR]
);
  localparam int MAXV = (2 ** (LLR_W - 1)) - 1;
  localparam int MINV = -(2 ** (LLR_W - 1));
  localparam logic [LLR_W-2:0] MAXMAG = {(LLR_W-1){1'b1}};

  function automatic logic signed [LLR_W-1:0] clamp_llr(input logic signed [LLR_W:0] x);
    if (x > MAXV)      return LLR_W'(MAXV);
    else if (x < MINV) return LLR_W'(MINV);
    else               return x[LLR_W-1:0];
  endfunction

  function automatic logic [LLR_W-2:0] abs_cap(input logic signed [LLR_W-1:0] v);
    logic signed [LLR_W:0] w;
    w = v;
    if (w < 0) w = -w;
    if (w > MAXV) return MAXMAG;
    return w[LLR_W-2:0];
  endfunction

  function automatic logic [LLR_W-2:0] scale_34(input logic [LLR_W-2:0] m);
    return m - (m >> 2);
  endfunction

  logic signed [LLR_W-1:0] v2c   [NUM_VAR];
  logic [LLR_W-2:0]        mag   [NUM_VAR];
  logic [NUM_VAR-1:0]      sgn;
  logic [LLR_W-2:0]        min1, min2, other, sc;
  int                      min1_idx;
  logic                    par, osign;
  logic signed [LLR_W-1:0] newmsg;
  logic signed [LLR_W:0]   dsum;

  always_comb begin
    for (int j = 0; j < NUM_VAR; j++) begin
      dsum   = LLR_W'(post_in[j]) - LLR_W'(msg_in[j]);
      dsum   = (LLR_W+1)'(post_in[j]) - (LLR_W+1)'(msg_in[j]);
      v2c[j] = clamp_llr(dsum);
      mag[j] = abs_cap(v2c[j]);
      sgn[j] = v2c[j][LLR_W-1];
    end
    min1     = MAXMAG;
    min2     = MAXMAG;
    min1_idx = 0;
    par      = syn_bit;
    for (int j = 0; j < NUM_VAR; j++) begin
      if (edge_mask[j]) begin
        par = par ^ sgn[j];
        if (mag[j] < min1) begin
          min2     = min1;
          min1     = mag[j];
          min1_idx = j;
        end else if (mag[j] < min2) begin
          min2 = mag[j];
        end
      end
    end
    for (int j = 0; j < NUM_VAR; j++) begin
      other  = (j == min1_idx) ? min2 : min1;
      sc     = scale_34(other);
      osign  = par ^ sgn[j];
      newmsg = osign ? -$signed({1'b0, sc}) : $signed({1'b0, sc});
      dsum   = (LLR_W+1)'(v2c[j]) + (LLR_W+1)'(newmsg);
      if (edge_mask[j]) begin
        msg_out[j]  = newmsg;
        post_out[j] = clamp_llr(dsum);
      end else begin
        msg_out[j]  = msg_in[j];
        post_out[j] = post_in[j];
      end
    end
  end
endmodule

// File: rtl/mn_layered_decoder.sv
module mn_layered_decoder #(
  parameter int NUM_VAR  = 8,
  parameter int NUM_CHK  = 4,
  parameter int NUM_ITER = 2,
  parameter int LLR_W    = 8,
  parameter logic [NUM_CHK*NUM_VAR-1:0] HMAT = 32'h9044_2A17,
  localparam int ROW_W   = (NUM_CHK > 1) ? $clog2(NUM_CHK) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_CHK-1:0]         syndrome,
  input  logic [NUM_VAR*LLR_W-1:0]   prior_llr,
  output logic                       busy,
  output logic                       done,
  output logic [NUM_VAR*LLR_W-1:0]   post_llr,
  output logic [NUM_VAR-1:0]         hard_dec
);
  logic                    load;
  logic [ROW_W-1:0]        row_q;
  logic [NUM_CHK-1:0]      syn_q;
  logic signed [LLR_W-1:0] post_q  [NUM_VAR];
  logic signed [LLR_W-1:0] msg_q   [NUM_CHK][NUM_VAR];
  logic signed [LLR_W-1:0] msg_row [NUM_VAR];
  logic signed [LLR_W-1:0] post_nx [NUM_VAR];
  logic signed [LLR_W-1:0] msg_nx  [NUM_VAR];
  logic [NUM_VAR-1:0]      row_mask;
  logic                    row_syn;

  mn_ctrl #(.NUM_CHK(NUM_CHK), .NUM_ITER(NUM_ITER)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .load  (load),
    .row_q (row_q)
  );

  always_comb begin
    row_mask = HMAT[int'(row_q)*NUM_VAR +: NUM_VAR];
    row_syn  = syn_q[row_q];
    for (int j = 0; j < NUM_VAR; j++) msg_row[j] = msg_q[row_q][j];
  end

  mn_row_update #(.NUM_VAR(NUM_VAR), .LLR_W(LLR_W)) u_row (
    .edge_mask (row_mask),
    .syn_bit   (row_syn),
    .post_in   (post_q),
    .msg_in    (msg_row),
    .post_out  (post_nx),
    .msg_out   (msg_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q <= '0;
      for (int j = 0; j < NUM_VAR; j++) begin
        post_q[j] <= '0;
        for (int r = 0; r < NUM_CHK; r++) msg_q[r][j] <= '0;
      end
    end else if (load) begin
      syn_q <= syndrome;
      for (int j = 0; j < NUM_VAR; j++) begin
        post_q[j] <= prior_llr[j*LLR_W +: LLR_W];
        for (int r = 0; r < NUM_CHK; r++) msg_q[r][j] <= '0;
      end
    end else if (busy) begin
      for (int j = 0; j < NUM_VAR; j++) begin
        post_q[j]        <= post_nx[j];
        msg_q[row_q][j]  <= msg_nx[j];
      end
    end
  end

  for (genvar j = 0; j < NUM_VAR; j++) begin : g_out
    assign post_llr[j*LLR_W +: LLR_W] = post_q[j];
    assign hard_dec[j]                = post_q[j][LLR_W-1];

    AST_OFF_ROW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load && !row_mask[j]) |=> (post_q[j] == $past(post_q[j]))); // R7
  end

  AST_LOAD_PRIORS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (post_llr == $past(prior_llr))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(post_llr)); // R10
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load); // R2
endmodule

// File: tb/mn_layered_decoder_bench.sv
module mn_layered_decoder_bench;
  localparam int N  = 8;
  localparam int M  = 4;
  localparam int IT = 2;
  localparam int W  = 8;
  localparam logic [M*N-1:0] H = 32'h9044_2A17;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [M-1:0]     syndrome = '0;
  logic [N*W-1:0]   prior_llr = '0;
  logic             busy, done;
  logic [N*W-1:0]   post_llr;
  logic [N-1:0]     hard_dec;

  int n_chk = 0;
  int n_fail = 0;
  int m_post [N];
  int m_msg  [M][N];

  always #10 clk = ~clk;

  mn_layered_decoder #(.NUM_VAR(N), .NUM_CHK(M), .NUM_ITER(IT), .LLR_W(W), .HMAT(H))
    u_mn_layered_decoder (.clk(clk), .rst_n(rst_n), .start(start), .syndrome(syndrome),
      .prior_llr(prior_llr), .busy(busy), .done(done), .post_llr(post_llr), .hard_dec(hard_dec));

  function automatic int clampi(input int x);
    if (x > 127) return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference: for each edge, explicit scan over the other edges of the row.
  task automatic model(input logic [M-1:0] syn, input int pr [N]);
    int v [N];
    for (int j = 0; j < N; j++) begin
      m_post[j] = pr[j];
      for (int r = 0; r < M; r++) m_msg[r][j] = 0;
    end
    for (int it = 0; it < IT; it++)
      for (int r = 0; r < M; r++) begin
        for (int j = 0; j < N; j++) v[j] = clampi(m_post[j] - m_msg[r][j]);
        for (int j = 0; j < N; j++) begin
          if (H[r*N + j]) begin
            int mn;
            int s;
            int sc;
            mn = 127;
            s  = syn[r];
            for (int k = 0; k < N; k++)
              if (k != j && H[r*N + k]) begin
                int a;
                a = (v[k] < 0) ? -v[k] : v[k];
                if (a > 127) a = 127;
                if (a < mn) mn = a;
                if (v[k] < 0) s = s ^ 1;
              end
            sc = mn - mn / 4;
            m_msg[r][j] = s ? -sc : sc;
            m_post[j]   = clampi(v[j] + m_msg[r][j]);
          end
        end
      end
  endtask

  function automatic int out_llr(input int j);
    return int'($signed(post_llr[j*W +: W]));
  endfunction

  task automatic compare_all(input string tag);
    for (int j = 0; j < N; j++) begin
      check(out_llr(j) == m_post[j], tag, out_llr(j), m_post[j]);
      check(hard_dec[j] == (m_post[j] < 0), "R9 hard decision", int'(hard_dec[j]), int'(m_post[j] < 0));
    end
  endtask

  task automatic decode(input logic [M-1:0] syn, input int pr [N], input bit poke, input string tag);
    int n;
    @(negedge clk);
    syndrome = syn;
    for (int j = 0; j < N; j++) prior_llr[j*W +: W] = W'(pr[j]);
    start = 1'b1;
    model(syn, pr);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 200) begin
      if (poke && n == 3) begin
        start = 1'b1;
        syndrome = ~syn;
        prior_llr = ~prior_llr;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == M*IT + 1, "R8 latency", n, M*IT + 1);
    check(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
    compare_all(tag);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pr [N];
    void'($urandom(32'h1F2E));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(post_llr == '0, "R1 posterior", int'(post_llr[31:0]), 0);
    check(hard_dec == '0, "R1 hard", int'(hard_dec), 0);
    rst_n = 1'b1;

    // directed: zero priors, zero syndrome
    for (int j = 0; j < N; j++) pr[j] = 0;
    decode('0, pr, 1'b0, "R3 zero priors");
    // positive saturation limit, all syndrome bits set (R6 sign inversion)
    for (int j = 0; j < N; j++) pr[j] = 127;
    decode('1, pr, 1'b0, "R6/R7 saturated positive");
    // negative saturation limit
    for (int j = 0; j < N; j++) pr[j] = -128;
    decode(4'b0101, pr, 1'b0, "R4/R5 saturated negative");
    // two-edge row ordering: one weak bit on the degree-2 row
    for (int j = 0; j < N; j++) pr[j] = 40;
    pr[4] = -3;
    decode(4'b1000, pr, 1'b0, "R5 min exclusion");

    // start during a decode is ignored
    for (int j = 0; j < N; j++) pr[j] = int'($urandom_range(0, 60)) - 30;
    decode(4'b0110, pr, 1'b1, "R2 start while busy");

    // outputs hold while idle
    prior_llr = ~prior_llr;
    repeat (5) @(negedge clk);
    compare_all("R10 idle hold");

    // random decodes
    for (int t = 0; t < 24; t++) begin
      for (int j = 0; j < N; j++)
        pr[j] = (t % 2 == 0) ? int'($urandom_range(0, 255)) - 128 : int'($urandom_range(0, 40)) - 20;
      decode(M'($urandom), pr, 1'b0, "R3/R4/R5/R6/R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule